// File: doc/BRIEF.md
# SPI transmit/receive FIFO pair with watermark interrupt

This block sits between a memory-mapped register port and a serial shift engine. It holds two byte queues. The transmit queue is filled by register writes and drained by the engine. The receive queue is filled by the engine and drained by register reads. Each data register shows its queue's occupancy flag in bit 31. Software can therefore test for room or for data in the same access that moves a byte.

Two mark registers set occupancy thresholds. Each threshold comparison drives a live pending bit. An enable register gates the pending bits into a single interrupt line. The transmit pending bit asks for more data while the queue holds fewer entries than its mark. The receive pending bit reports data while the queue holds more entries than its mark.

Register word addresses on `reg_addr_i` are 0 transmit data, 1 receive data, 2 transmit mark, 3 receive mark, 4 interrupt enable and 5 pending. Reads are combinational. Writes and pops take effect at the clock edge.

Top module: `spi_fifo_irq`

## Requirements
- R1: A write to address 0 queues `reg_wdata_i[7:0]`. While the transmit queue is not empty, `eng_tx_valid_o` is 1 and `eng_tx_data_o` shows the oldest byte. `eng_tx_pop_i` removes that byte, and is ignored when the queue is empty.
- R2: A read of address 0 returns bit 31 = transmit queue full, with all other bits 0. A write to address 0 while the queue is full is dropped, even if the engine pops in the same cycle.
- R3: A read of address 1 returns the oldest receive byte in bits [7:0] and bit 31 = receive queue empty. A strobed read pops that byte when the queue is not empty. When the queue is empty, the read returns data 0 and removes nothing.
- R4: An `eng_rx_push_i` while the receive queue is full is dropped, and the stored bytes are kept, even if software pops in the same cycle.
- R5: Pending bit 0 is 1 exactly while the transmit entry count is strictly less than the transmit mark.
- R6: Pending bit 1 is 1 exactly while the receive entry count is strictly greater than the receive mark.
- R7: The pending register at address 5 is read-only and not sticky. Writes to it have no effect, and its bits follow the counts in the cycle after they change.
- R8: The enable register at address 4 holds bit 0 for transmit and bit 1 for receive. `irq_o` is the OR of each pending bit ANDed with its enable bit.
- R9: After reset both queues are empty, the enables are 0, the transmit mark is 1 and the receive mark is 0. Pending therefore reads 1 and `irq_o` is 0.
- R10: Both queues are first-in first-out with DEPTH entries (default 8). A push and a pop on the same queue in one cycle both take effect when the queue is neither full nor empty.
- R11: The mark registers keep the low $clog2(DEPTH+1) bits of the written word and read back zero-extended. Reads of addresses 6 and 7 return 0, and writes to addresses 1, 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops receive data at address 1) |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from address |
| eng_tx_valid_o | output | 1 | Transmit queue holds a byte |
| eng_tx_data_o | output | 8 | Oldest transmit byte |
| eng_tx_pop_i | input | 1 | Engine consumes the transmit byte |
| eng_rx_push_i | input | 1 | Engine delivers a received byte |
| eng_rx_data_i | input | 8 | Received byte |
| irq_o | output | 1 | Watermark interrupt |

## Verification
Two pairs of events can meet in one clock: a software write to the transmit queue with an engine pop, and an engine receive push with a software read that pops. The random phase drives both sides independently every cycle. Directed sequences also fill each queue to DEPTH and then apply push and pop together. Each such cycle is judged against a queue model in the bench. The model applies the pop, rejects any push to a full queue, and then recomputes the data flags, the pending bits and the interrupt.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int unsigned REG_ADDR_W = 3;
  typedef enum logic [REG_ADDR_W-1:0] {
    REG_TXDATA = 3'd0,
    REG_RXDATA = 3'd1,
    REG_TXMARK = 3'd2,
    REG_RXMARK = 3'd3,
    REG_IRQ_EN = 3'd4,
    REG_IRQ_PEND = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] count_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic push_ok, pop_ok;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;
  assign data_o  = mem_q[rd_q];
  // full rejects push even with a concurrent pop
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;

  function automatic logic [PTR_W-1:0] inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= inc(wr_q);
      if (pop_ok) rd_q <= inc(rd_q);
      if (push_ok && !pop_ok) cnt_q <= cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_ok) begin
      mem_q[wr_q] <= data_i;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH)); // R10
  AST_FULL_PUSH_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> full_o && $stable(wr_q)); // R2
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> empty_o && $stable(rd_q)); // R3
endmodule

// File: rtl/wm_level.sv
module wm_level #(
  parameter int unsigned CNT_W = 4,
  parameter logic [CNT_W-1:0] RST_MARK = '0,
  parameter bit ABOVE = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CNT_W-1:0] mark_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] mark_o,
  output logic             pend_o
);
  logic [CNT_W-1:0] mark_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mark_q <= RST_MARK;
    else if (we_i) mark_q <= mark_i;
  end

  assign mark_o = mark_q;

  generate
    if (ABOVE) begin : g_above
      assign pend_o = count_i > mark_q;
    end else begin : g_below
      assign pend_o = count_i < mark_q;
    end
  endgenerate
endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq
  import spi_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_we_i,
  input  logic                  reg_re_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]           reg_wdata_i,
  output logic [31:0]           reg_rdata_o,
  output logic                  eng_tx_valid_o,
  output logic [7:0]            eng_tx_data_o,
  input  logic                  eng_tx_pop_i,
  input  logic                  eng_rx_push_i,
  input  logic [7:0]            eng_rx_data_i,
  output logic                  irq_o
);
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic [CNT_W-1:0] tx_cnt, rx_cnt, tx_mark, rx_mark;
  logic [7:0] rx_head;
  logic [1:0] en_q, pend;
  logic tx_push, rx_pop;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata_i[31:8];
  assign tx_push = reg_we_i && (reg_addr_i == REG_TXDATA);
  assign rx_pop  = reg_re_i && (reg_addr_i == REG_RXDATA);

  byte_fifo #(.DEPTH(DEPTH), .WIDTH(8)) i_tx_fifo (
    .clk_i, .rst_ni,
    .push_i(tx_push), .data_i(reg_wdata_i[7:0]),
    .pop_i(eng_tx_pop_i), .data_o(eng_tx_data_o),
    .full_o(tx_full), .empty_o(tx_empty), .count_o(tx_cnt)
  );

  byte_fifo #(.DEPTH(DEPTH), .WIDTH(8)) i_rx_fifo (
    .clk_i, .rst_ni,
    .push_i(eng_rx_push_i), .data_i(eng_rx_data_i),
    .pop_i(rx_pop), .data_o(rx_head),
    .full_o(rx_full), .empty_o(rx_empty), .count_o(rx_cnt)
  );

  wm_level #(.CNT_W(CNT_W), .RST_MARK(CNT_W'(1)), .ABOVE(1'b0)) i_tx_wm (
    .clk_i, .rst_ni,
    .we_i(reg_we_i && (reg_addr_i == REG_TXMARK)),
    .mark_i(reg_wdata_i[CNT_W-1:0]), .count_i(tx_cnt),
    .mark_o(tx_mark), .pend_o(pend[0])
  );

  wm_level #(.CNT_W(CNT_W), .RST_MARK('0), .ABOVE(1'b1)) i_rx_wm (
    .clk_i, .rst_ni,
    .we_i(reg_we_i && (reg_addr_i == REG_RXMARK)),
    .mark_i(reg_wdata_i[CNT_W-1:0]), .count_i(rx_cnt),
    .mark_o(rx_mark), .pend_o(pend[1])
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else if (reg_we_i && (reg_addr_i == REG_IRQ_EN)) en_q <= reg_wdata_i[1:0];
  end

  assign irq_o = |(pend & en_q);
  assign eng_tx_valid_o = !tx_empty;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      REG_TXDATA:   reg_rdata_o[31] = tx_full;
      REG_RXDATA: begin
        reg_rdata_o[31]  = rx_empty;
        reg_rdata_o[7:0] = rx_empty ? 8'h00 : rx_head;
      end
      REG_TXMARK:   reg_rdata_o[CNT_W-1:0] = tx_mark;
      REG_RXMARK:   reg_rdata_o[CNT_W-1:0] = rx_mark;
      REG_IRQ_EN:   reg_rdata_o[1:0] = en_q;
      REG_IRQ_PEND: reg_rdata_o[1:0] = pend;
      default:      reg_rdata_o = '0;
    endcase
  end

  AST_RX_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full && eng_rx_push_i && !rx_pop) |=> rx_full && $stable(rx_head)); // R4
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en_q != 2'b00)); // R8
  AST_TX_EMPTY_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_empty && tx_mark != '0) |-> pend[0]); // R5
  AST_RX_EMPTY_NO_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty |-> !pend[1]); // R6
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pop && rx_empty) |-> (reg_rdata_o == 32'h8000_0000)); // R3
endmodule

// File: tb/test_spi_fifo_irq.sv
module test_spi_fifo_irq;
  localparam int D = 8;
  localparam int MW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0, re = 1'b0, txpop = 1'b0, rxpush = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [7:0] rxdata = '0;
  logic [31:0] rdata;
  logic txv, irq;
  logic [7:0] txd;

  int n_chk = 0, n_fail = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  int txmark = 1, rxmark = 0, en = 0;

  always #5 clk = ~clk;

  spi_fifo_irq #(.DEPTH(D)) i_spi_fifo_irq (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .eng_tx_valid_o(txv), .eng_tx_data_o(txd),
    .eng_tx_pop_i(txpop), .eng_rx_push_i(rxpush), .eng_rx_data_i(rxdata),
    .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_pend();
    return {(rxq.size() > rxmark), (txq.size() < txmark)};
  endfunction

  function automatic logic [31:0] exp_rdata(input logic [2:0] a);
    logic [31:0] r = '0;
    case (a)
      3'd0: r[31] = (txq.size() == D);
      3'd1: begin r[31] = (rxq.size() == 0); if (rxq.size() > 0) r[7:0] = rxq[0]; end
      3'd2: r = 32'(txmark);
      3'd3: r = 32'(rxmark);
      3'd4: r = 32'(en);
      3'd5: r = {30'd0, exp_pend()};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2, 3'd3: return "R11";
      3'd4: return "R8";
      3'd5: return "R7";
      default: return "R11";
    endcase
  endfunction

  // one cycle: drive at negedge, check combinational view, update model at edge
  task automatic step(input logic w, input logic r, input logic [2:0] a, input logic [31:0] wd,
                      input logic tp, input logic rp, input logic [7:0] rd, input string tag);
    bit tx_push, tx_pop, rx_push, rx_pop;
    @(negedge clk);
    we = w; re = r; addr = a; wdata = wd; txpop = tp; rxpush = rp; rxdata = rd;
    #1;
    check(tag, rdata, exp_rdata(a));
    check("R1 valid", 32'(txv), 32'(txq.size() > 0));
    if (txq.size() > 0) check("R1 data", 32'(txd), 32'(txq[0]));
    check("R8 irq", 32'(irq), 32'(|(exp_pend() & en[1:0])));
    tx_push = w && a == 3'd0 && txq.size() < D;
    tx_pop  = tp && txq.size() > 0;
    rx_push = rp && rxq.size() < D;
    rx_pop  = r && a == 3'd1 && rxq.size() > 0;
    @(posedge clk);
    if (tx_pop) void'(txq.pop_front());
    if (tx_push) txq.push_back(wd[7:0]);
    if (rx_pop) void'(rxq.pop_front());
    if (rx_push) rxq.push_back(rd);
    if (w && a == 3'd2) txmark = int'(wd[MW-1:0]);
    if (w && a == 3'd3) rxmark = int'(wd[MW-1:0]);
    if (w && a == 3'd4) en = int'(wd[1:0]);
  endtask

  task automatic idle_read(input logic [2:0] a, input string tag);
    step(1'b0, 1'b0, a, 32'd0, 1'b0, 1'b0, 8'd0, tag);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R9 reset state
    idle_read(3'd5, "R9 pend");
    idle_read(3'd2, "R9 txmark");
    idle_read(3'd3, "R9 rxmark");
    idle_read(3'd4, "R9 en");
    idle_read(3'd1, "R9 rx empty");
    // R3 empty read pops nothing
    step(1'b0, 1'b1, 3'd1, 0, 1'b0, 1'b0, 8'd0, "R3 empty read");
    // R2 R10 fill tx past full, order kept
    for (int i = 0; i < D + 2; i++) step(1'b1, 1'b0, 3'd0, 32'hA0 + i, 1'b0, 1'b0, 0, "R2 fill");
    idle_read(3'd0, "R2 full flag");
    step(1'b1, 1'b0, 3'd0, 32'h55, 1'b1, 1'b0, 0, "R2 write+pop full");
    idle_read(3'd0, "R2 after pop");
    step(1'b1, 1'b0, 3'd0, 32'h66, 1'b1, 1'b0, 0, "R10 push+pop mid");
    // R7 pending write ignored
    step(1'b1, 1'b0, 3'd5, 32'hFFFF_FFFF, 1'b0, 1'b0, 0, "R7 write");
    idle_read(3'd5, "R7 readback");
    // R5 mark tuning, R8 enable
    step(1'b1, 1'b0, 3'd2, 32'hFFFF_FFF9, 1'b0, 1'b0, 0, "R11 txmark write");
    step(1'b1, 1'b0, 3'd4, 32'h3, 1'b0, 1'b0, 0, "R8 en write");
    while (txq.size() > 0) step(1'b0, 1'b0, 3'd5, 0, 1'b1, 1'b0, 0, "R5 drain");
    idle_read(3'd5, "R5 empty");
    // R4 R6 rx overflow
    for (int i = 0; i < D + 3; i++) step(1'b0, 1'b0, 3'd5, 0, 1'b0, 1'b1, 8'h30 + i, "R6 fill");
    step(1'b0, 1'b1, 3'd1, 0, 1'b0, 1'b1, 8'hEE, "R4 pop+push full");
    step(1'b1, 1'b0, 3'd3, 32'd5, 1'b0, 1'b0, 0, "R11 rxmark write");
    while (rxq.size() > 0) step(1'b0, 1'b1, 3'd1, 0, 1'b0, 1'b0, 0, "R3 drain");
    idle_read(3'd6, "R11 unmapped");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] a = 3'($urandom_range(0, 7));
      logic [31:0] wd = ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 9)) : $urandom;
      bit heavy_rx = (i / 500) % 2 == 1;
      step(($urandom_range(0, 9) < 3), ($urandom_range(0, 9) < 3), a, wd,
           ($urandom_range(0, 9) < (heavy_rx ? 6 : 2)),
           ($urandom_range(0, 9) < (heavy_rx ? 6 : 3)),
           8'($urandom), tag_of(a));
    end
    finish_run();
  end
endmodule